// File: doc/BRIEF.md
# ALC Gain Ramp Rate Controller

This block owns the gain code of an automatic level control loop placed in front of an input amplifier. A level detector outside the block reports two flags each cycle: the signal sits above the target, or the signal sits below it. When only the "above" flag is set, the block lowers the gain one code at a time (attack). When only the "below" flag is set, it raises the gain one code at a time (decay). The time between two steps is measured in ticks of a 1 µs timebase. It depends on the step direction, on a normal/limiter mode bit and on a 4-bit rate code per direction.

Software programs the loop through a small write port: a control word (mode, zero-cross option, enable request, mute), the two rate codes and a manual gain value. With the zero-cross option set, a step that has fallen due waits until the input sample changes sign, so that the gain changes near a zero crossing. When the loop is off, the gain holds its last value, and only a manual gain write moves it.

Top module: `alc_ramp_ctrl`

## Requirements
- R1: After reset the gain equals parameter GAIN_RST, `alc_active` is 0, the mode is normal ALC, zero-cross is off, the attack code is 2 and the decay code is 3.
- R2: When `above` alone is high, steps decrement the gain. When `below` alone is high, steps increment it. When both or neither are high, the gain does not move. Every step changes the gain by exactly one code.
- R3: The step interval in ticks is the base count shifted left by the rate code. The bases are ALC_ATK_BASE and ALC_DCY_BASE in normal mode, and LIM_ATK_BASE and LIM_DCY_BASE in limiter mode. Limiter mode is bit 0 of the control word (address 0). The attack code is written at address 1 and the decay code at address 2, in data bits 3:0.
- R4: With `tick` high every cycle and a direction held for K clock edges, counted from the first edge that sees it, the gain has moved floor((K-1)/N) steps, where N is the interval.
- R5: Rate codes 10 to 15 all give the same interval as code 10.
- R6: The interval advances only on cycles where `tick` is high.
- R7: The gain saturates at 0 and at 63 and never wraps.
- R8: The interval timer restarts from zero when the direction changes, when the direction is hold, and on any write to address 0, 1 or 2.
- R9: With zero-cross on (control bit 1), a step that has fallen due is applied only on a cycle where `sample_sign` differs from its value in the previous cycle. A pending step is applied once, however many intervals have passed.
- R10: A control write turns the loop on only when the enable bit (bit 2) is 1 and the mute bit (bit 3) is 0. Any other control write turns it off. `alc_active` shows the loop state.
- R11: While the loop is off, the gain holds, and a write to address 3 loads data bits 5:0 into the gain. While the loop is on, a write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse of the 1 µs timebase |
| above | input | 1 | Level is above the target |
| below | input | 1 | Level is below the target |
| sample_sign | input | 1 | Sign bit of the current input sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 attack code, 2 decay code, 3 manual gain |
| wr_data | input | 6 | Register write data |
| gain | output | 6 | Gain code to the amplifier |
| alc_active | output | 1 | Loop is running |

## Verification
The step engine is driven with held attack, decay, both-flag and no-flag patterns of random length, in both modes and with several codes. The resulting gain shows whether the direction decoding and the N-edge interval arithmetic are right. Directed runs hold a direction for exactly N and N+1 edges at code 10 and code 15, which separates correct clamping from an unclamped shift. A direction flip partway through an interval, and a register write partway through one, show whether a stale count can cause an early step. Zero-cross runs hold the sign steady across several intervals and then flip it twice, which tells a pending flag apart from a counted backlog. The mute, disable and manual-write patterns tell a frozen gain apart from one that is still driven.

// File: rtl/alc_ramp_pkg.sv
package alc_ramp_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_ATK  = 2'd1,
    DIR_DCY  = 2'd2
  } dir_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ATK  = 2'd1;
  localparam logic [1:0] REG_DCY  = 2'd2;
  localparam logic [1:0] REG_GAIN = 2'd3;

  localparam int CTRL_LIM  = 0;
  localparam int CTRL_ZC   = 1;
  localparam int CTRL_EN   = 2;
  localparam int CTRL_MUTE = 3;

  localparam int CODE_W     = 4;
  localparam int CODE_CLAMP = 10;

  localparam logic [CODE_W-1:0] ATK_RST = 4'd2;
  localparam logic [CODE_W-1:0] DCY_RST = 4'd3;

  typedef struct packed {
    logic              limiter;
    logic              zc_en;
    logic [CODE_W-1:0] atk;
    logic [CODE_W-1:0] dcy;
  } cfg_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/alc_cfg_regs.sv
module alc_cfg_regs
  import alc_ramp_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic              alc_on,
  output logic              cfg_touch,
  output logic              man_load,
  output logic [GAIN_W-1:0] man_gain
);

  logic ctrl_wr, atk_wr, dcy_wr;

  always_comb begin
    ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
    atk_wr    = wr_en && (wr_addr == REG_ATK);
    dcy_wr    = wr_en && (wr_addr == REG_DCY);
    man_load  = wr_en && (wr_addr == REG_GAIN);
    man_gain  = wr_data[GAIN_W-1:0];
    cfg_touch = ctrl_wr || atk_wr || dcy_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.limiter <= 1'b0;
      cfg.zc_en   <= 1'b0;
      cfg.atk     <= ATK_RST;
      cfg.dcy     <= DCY_RST;
      alc_on      <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        cfg.limiter <= wr_data[CTRL_LIM];
        cfg.zc_en   <= wr_data[CTRL_ZC];
        alc_on      <= wr_data[CTRL_EN] & ~wr_data[CTRL_MUTE];
      end
      if (atk_wr) cfg.atk <= wr_data[CODE_W-1:0];
      if (dcy_wr) cfg.dcy <= wr_data[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer
  import alc_ramp_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int ALC_ATK_BASE = 104,
  parameter int ALC_DCY_BASE = 410,
  parameter int LIM_ATK_BASE = 23,
  parameter int LIM_DCY_BASE = 91
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  dir_e              dir,
  input  logic              limiter,
  input  logic [CODE_W-1:0] atk_code,
  input  logic [CODE_W-1:0] dcy_code,
  input  logic              cfg_touch,
  output logic              flush,
  output logic              expire
);

  localparam logic [CODE_W-1:0] CLAMP = CODE_W'(CODE_CLAMP);

  logic [CODE_W-1:0] code_sel, shamt;
  logic [CNT_W-1:0]  base_sel, interval, last, cnt;
  dir_e              dir_q;

  always_comb begin
    code_sel = (dir == DIR_DCY) ? dcy_code : atk_code;
    shamt    = (code_sel > CLAMP) ? CLAMP : code_sel;
    unique case ({limiter, dir == DIR_DCY})
      2'b00:   base_sel = CNT_W'(ALC_ATK_BASE);
      2'b01:   base_sel = CNT_W'(ALC_DCY_BASE);
      2'b10:   base_sel = CNT_W'(LIM_ATK_BASE);
      default: base_sel = CNT_W'(LIM_DCY_BASE);
    endcase
    interval = base_sel << shamt;
    last     = interval - 1'b1;
    flush    = cfg_touch || !active || (dir == DIR_HOLD) || (dir != dir_q);
    expire   = !flush && tick && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= DIR_HOLD;
    end else begin
      dir_q <= dir;
      if (flush)       cnt <= '0;
      else if (expire) cnt <= '0;
      else if (tick)   cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/alc_gain_core.sv
module alc_gain_core
  import alc_ramp_pkg::*;
#(
  parameter int                 GAIN_W   = 6,
  parameter logic [GAIN_W-1:0]  GAIN_RST = 6'd32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  dir_e              dir,
  input  logic              flush,
  input  logic              expire,
  input  logic              zc_en,
  input  logic              sample_sign,
  input  logic              man_load,
  input  logic [GAIN_W-1:0] man_gain,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] G_MAX = '1;
  localparam logic [GAIN_W-1:0] G_MIN = '0;

  logic sign_q, pending, flip, due, apply;

  always_comb begin
    flip  = sample_sign ^ sign_q;
    due   = expire || (pending && !flush);
    apply = zc_en ? (due && flip) : expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sign_q  <= 1'b0;
      pending <= 1'b0;
      gain    <= GAIN_RST;
    end else begin
      sign_q <= sample_sign;
      if (flush || !zc_en) pending <= 1'b0;
      else if (apply)      pending <= 1'b0;
      else if (expire)     pending <= 1'b1;

      if (!active) begin
        if (man_load) gain <= man_gain;
      end else if (apply) begin
        if (dir == DIR_ATK && gain != G_MIN)      gain <= gain - 1'b1;
        else if (dir == DIR_DCY && gain != G_MAX) gain <= gain + 1'b1;
      end
    end
  end

endmodule

// File: rtl/alc_ramp_ctrl.sv
module alc_ramp_ctrl
  import alc_ramp_pkg::*;
#(
  parameter int                GAIN_W       = 6,
  parameter logic [GAIN_W-1:0] GAIN_RST     = 6'd32,
  parameter int                ALC_ATK_BASE = 104,
  parameter int                ALC_DCY_BASE = 410,
  parameter int                LIM_ATK_BASE = 23,
  parameter int                LIM_DCY_BASE = 91
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              above,
  input  logic              below,
  input  logic              sample_sign,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  output logic [GAIN_W-1:0] gain,
  output logic              alc_active
);

  localparam int MAX_BASE = max2(max2(ALC_ATK_BASE, ALC_DCY_BASE),
                                 max2(LIM_ATK_BASE, LIM_DCY_BASE));
  localparam int CNT_W    = $clog2((MAX_BASE << CODE_CLAMP) + 1);

  cfg_t              cfg;
  logic              alc_on, cfg_touch, man_load, flush, expire, cfg_zc;
  logic [GAIN_W-1:0] man_gain;
  dir_e              dir;

  always_comb begin
    unique case ({above, below})
      2'b10:   dir = DIR_ATK;
      2'b01:   dir = DIR_DCY;
      default: dir = DIR_HOLD;
    endcase
    cfg_zc     = cfg.zc_en;
    alc_active = alc_on;
  end

  alc_cfg_regs #(.DATA_W(GAIN_W), .GAIN_W(GAIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .alc_on(alc_on), .cfg_touch(cfg_touch),
    .man_load(man_load), .man_gain(man_gain)
  );

  alc_step_timer #(
    .CNT_W(CNT_W), .ALC_ATK_BASE(ALC_ATK_BASE), .ALC_DCY_BASE(ALC_DCY_BASE),
    .LIM_ATK_BASE(LIM_ATK_BASE), .LIM_DCY_BASE(LIM_DCY_BASE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(alc_on), .dir(dir),
    .limiter(cfg.limiter), .atk_code(cfg.atk), .dcy_code(cfg.dcy),
    .cfg_touch(cfg_touch), .flush(flush), .expire(expire)
  );

  alc_gain_core #(.GAIN_W(GAIN_W), .GAIN_RST(GAIN_RST)) u_core (
    .clk(clk), .rst_n(rst_n), .active(alc_on), .dir(dir), .flush(flush),
    .expire(expire), .zc_en(cfg_zc), .sample_sign(sample_sign),
    .man_load(man_load), .man_gain(man_gain), .gain(gain)
  );

endmodule

// File: rtl/alc_ramp_ctrl_chk.sv
module alc_ramp_ctrl_chk #(
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              above,
  input logic              below,
  input logic              sample_sign,
  input logic              ctrl_wr,
  input logic              mute_bit,
  input logic              gain_wr,
  input logic              zc_on,
  input logic [GAIN_W-1:0] gain,
  input logic              alc_active
);

  localparam logic [GAIN_W-1:0] ONE   = 1;
  localparam logic [GAIN_W-1:0] G_MAX = '1;

  // R2: a running loop moves the gain by at most one code per cycle
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    alc_active |=> (gain == $past(gain) || gain == $past(gain) + ONE ||
                    gain == $past(gain) - ONE));

  // R2: both flags high means no movement
  a_r2_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_active && above && below) |=> $stable(gain));

  // R7: no wrap at either end
  a_r7_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_active && gain == '0) |=> gain != G_MAX);
  a_r7_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_active && gain == G_MAX) |=> gain != '0);

  // R9: with zero-cross on, gain moves only on a sign change
  a_r9_zc_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_on && alc_active) |=>
      ($stable(gain) || $past(sample_sign) != $past(sample_sign, 2)));

  // R10: a control write with mute set leaves the loop off
  a_r10_mute_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && mute_bit) |=> !alc_active);

  // R11: loop off and no manual write means the gain is frozen
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!alc_active && !gain_wr) |=> $stable(gain));

endmodule

bind alc_ramp_ctrl alc_ramp_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .above(above), .below(below),
  .sample_sign(sample_sign),
  .ctrl_wr(wr_en && wr_addr == 2'd0), .mute_bit(wr_data[3]),
  .gain_wr(wr_en && wr_addr == 2'd3), .zc_on(cfg_zc),
  .gain(gain), .alc_active(alc_active)
);

// File: tb/tb_alc_ramp_ctrl.sv
module tb_alc_ramp_ctrl;

  localparam int AB = 3, DB = 5, LAB = 2, LDB = 4;
  localparam int G0 = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       above = 1'b0, below = 1'b0, sample_sign = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [5:0] wr_data = 6'd0;
  logic [5:0] gain;
  logic       alc_active;

  int total = 0, bad = 0, eg = G0;
  bit done = 0;

  always #5 clk = ~clk;

  alc_ramp_ctrl #(
    .GAIN_W(6), .GAIN_RST(6'(G0)), .ALC_ATK_BASE(AB), .ALC_DCY_BASE(DB),
    .LIM_ATK_BASE(LAB), .LIM_DCY_BASE(LDB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .above(above), .below(below),
    .sample_sign(sample_sign), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gain(gain), .alc_active(alc_active)
  );

  function automatic int interval(input bit lim, input bit dcy, input int code);
    int b, c;
    b = lim ? (dcy ? LDB : LAB) : (dcy ? DB : AB);
    c = (code > 10) ? 10 : code;
    return b << c;
  endfunction

  function automatic int moved(input int g, input int dir, input int steps);
    int r;
    r = g;
    if (dir == 1) r = g - steps;
    if (dir == 2) r = g + steps;
    if (r < 0) r = 0;
    if (r > 63) r = 63;
    return r;
  endfunction

  function automatic logic [5:0] ctrl_word(input bit lim, input bit zc,
                                           input bit en, input bit mute);
    return {2'b00, mute, en, zc, lim};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic seg(input bit a, input bit b, input int k);
    above = 1'b0; below = 1'b0;
    @(negedge clk);
    above = a; below = b;
    repeat (k) @(negedge clk);
    above = 1'b0; below = 1'b0;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset gain", gain, G0);
    check("R1 reset inactive", alc_active, 0);

    wr(2'd0, ctrl_word(0, 0, 1, 0));
    check("R10 enable", alc_active, 1);
    seg(0, 1, 2 * interval(0, 1, 3) + 1);
    eg = moved(eg, 2, 2);
    check("R1/R4 decay reset code", gain, eg);
    seg(1, 0, 2 * interval(0, 0, 2) + 1);
    eg = moved(eg, 1, 2);
    check("R1/R4 attack reset code", gain, eg);

    seg(1, 1, 60);
    check("R2 both flags", gain, eg);
    seg(0, 0, 60);
    check("R2 no flags", gain, eg);

    tick = 1'b0;
    seg(1, 0, 60);
    check("R6 tick low", gain, eg);
    tick = 1'b1;

    // R8: direction change restarts (atk N=3, dcy N=5)
    wr(2'd1, 6'd0);
    wr(2'd2, 6'd0);
    @(negedge clk);
    above = 1'b1;
    repeat (2) @(negedge clk);
    above = 1'b0; below = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 flip no early step", gain, eg);
    repeat (2) @(negedge clk);
    eg = moved(eg, 2, 1);
    check("R8 flip full interval", gain, eg);
    below = 1'b0;
    // R8: config write restarts
    @(negedge clk);
    above = 1'b1;
    repeat (2) @(negedge clk);
    wr(2'd1, 6'd0);
    repeat (2) @(negedge clk);
    check("R8 write no early step", gain, eg);
    @(negedge clk);
    eg = moved(eg, 1, 1);
    check("R8 write full interval", gain, eg);
    above = 1'b0;

    // R5: clamp at code 10
    wr(2'd2, 6'd10);
    seg(0, 1, interval(0, 1, 10) + 1);
    eg = moved(eg, 2, 1);
    check("R5 code 10", gain, eg);
    wr(2'd2, 6'd15);
    seg(0, 1, interval(0, 1, 10));
    check("R5 code 15 not early", gain, eg);
    seg(0, 1, interval(0, 1, 10) + 1);
    eg = moved(eg, 2, 1);
    check("R5 code 15 clamped", gain, eg);

    // R3: limiter mode bases
    wr(2'd0, ctrl_word(1, 0, 1, 0));
    wr(2'd1, 6'd3);
    seg(1, 0, 2 * interval(1, 0, 3) + 1);
    eg = moved(eg, 1, 2);
    check("R3 limiter attack", gain, eg);
    wr(2'd2, 6'd2);
    seg(0, 1, interval(1, 1, 2) + 1);
    eg = moved(eg, 2, 1);
    check("R3 limiter decay", gain, eg);

    // R7: saturation
    wr(2'd0, ctrl_word(0, 0, 0, 0));
    wr(2'd3, 6'd1);
    wr(2'd0, ctrl_word(0, 0, 1, 0));
    wr(2'd1, 6'd0);
    seg(1, 0, 30);
    eg = 0;
    check("R7 floor", gain, eg);
    wr(2'd0, ctrl_word(0, 0, 0, 0));
    wr(2'd3, 6'd62);
    wr(2'd0, ctrl_word(0, 0, 1, 0));
    wr(2'd2, 6'd0);
    seg(0, 1, 40);
    eg = 63;
    check("R7 ceiling", gain, eg);

    // R11: manual write ignored while active, frozen when off
    wr(2'd3, 6'd5);
    check("R11 manual ignored when on", gain, eg);
    wr(2'd0, ctrl_word(0, 0, 0, 0));
    check("R10 disable", alc_active, 0);
    seg(1, 0, 40);
    check("R11 frozen when off", gain, eg);
    wr(2'd3, 6'd40);
    eg = 40;
    check("R11 manual load", gain, eg);

    // R10: mute blocks enable
    wr(2'd0, ctrl_word(0, 0, 1, 1));
    check("R10 muted enable refused", alc_active, 0);
    seg(1, 0, 40);
    check("R10 muted gain still", gain, eg);

    // R9: zero-cross, atk N=3
    wr(2'd0, ctrl_word(0, 1, 1, 0));
    wr(2'd1, 6'd0);
    sample_sign = 1'b0;
    @(negedge clk);
    above = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 waits for sign change", gain, eg);
    sample_sign = 1'b1;
    @(negedge clk);
    eg = moved(eg, 1, 1);
    check("R9 step on sign change", gain, eg);
    sample_sign = 1'b0;
    @(negedge clk);
    check("R9 single pending step", gain, eg);
    above = 1'b0;

    // random segments: R2, R3, R4
    for (int i = 0; i < 40; i++) begin
      bit lim;
      int ac, dc, dsel, k, n;
      lim  = 1'($urandom % 2);
      ac   = $urandom % 5;
      dc   = $urandom % 5;
      dsel = 1 + $urandom % 3;
      k    = 1 + $urandom % 200;
      wr(2'd0, ctrl_word(lim, 0, 1, 0));
      wr(2'd1, 6'(ac));
      wr(2'd2, 6'(dc));
      if (dsel == 1) begin
        n = interval(lim, 0, ac);
        seg(1, 0, k);
        eg = moved(eg, 1, (k - 1) / n);
      end else if (dsel == 2) begin
        n = interval(lim, 1, dc);
        seg(0, 1, k);
        eg = moved(eg, 2, (k - 1) / n);
      end else begin
        seg(1, 1, k);
      end
      check($sformatf("R4 random seg %0d (R2/R3)", i), gain, eg);
    end

    done = 1;
    finish_up();
  end

endmodule